// File: doc/BRIEF.md
# Rate-1/2 Constraint-Length-7 Convolutional Encoder

This block turns a serial stream of information bits into a stream of coded symbol pairs for a rate-1/2 binary convolutional code with constraint length 7. Each information bit that the source offers and the block accepts produces, in that same cycle, two code bits. Each code bit is the modulo-2 sum of a fixed set of taps over the current bit and the six bits accepted before it. The generators are fixed at 171 and 133 octal.

The only storage is a six-bit history register. Its contents are the trellis state that a matching maximum-likelihood decoder tracks. The stream is encoded continuously, with no framing inside the block. A synchronous clear puts the history back to all zeros so that a new frame starts in state 0. To end a frame and bring the trellis back to state 0, the upstream source feeds six zero bits as a tail.

Top module: `cc_r12_k7_enc`

## Requirements
- R1: While and after reset (`rst_n` low), the history is all zeros, `in_ready_o` is high when `clr_i` is low, and `out_valid_o` is low while `in_valid_i` is low.
- R2: A bit is accepted in a cycle where `in_valid_i` and `in_ready_o` are both high. `out_valid_o` is high in exactly the accepting cycles, so every accepted bit yields exactly one symbol pair in that cycle.
- R3: `out_sym_o[1]` (the first symbol) is the XOR of the current bit and the past bits at delays 1, 2, 3 and 6. This is generator 1111001 (171 octal), with the leftmost generator bit applied to the current bit.
- R4: `out_sym_o[0]` (the second symbol) is the XOR of the current bit and the past bits at delays 2, 3, 5 and 6. This is generator 1011011 (133 octal).
- R5: On each accepted bit, that bit becomes the delay-1 history bit, every older bit moves one delay further back, and the bit at delay 6 is dropped.
- R6: A cycle without acceptance leaves the history unchanged and drives `out_valid_o` low. The bit on `in_bit_i` in such a cycle has no effect on later symbols.
- R7: While `clr_i` is high, `in_ready_o` is low and no bit is accepted. The history is all zeros in the cycle after `clr_i` is high.
- R8: Six accepted zero bits bring the history back to all zeros. From the all-zero state, a zero input bit gives symbol pair 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the history to state 0 |
| in_valid_i | input | 1 | Source offers a bit |
| in_ready_o | output | 1 | Encoder can accept a bit (low during clear) |
| in_bit_i | input | 1 | Information bit |
| out_valid_o | output | 1 | Symbol pair valid this cycle |
| out_sym_o | output | 2 | Bit 1: 171-octal output; bit 0: 133-octal output |

## Verification
Several input patterns are used, and each one separates a different kind of fault.

- **Single one followed by zeros.** This traces out both generator rows tap by tap, so any wrong or shifted tap shows up at its own delay.
- **Long run of ones.** This checks the weight of each generator.
- **Pseudo-random stream with stall gaps.** A wrong bit placed on the input during each gap tells apart a design that really holds its state from one that keeps shifting or samples the input while idle.
- **Clear mid-stream, and a six-zero tail.** These show that the trellis returns to state 0 and that a fresh single one then reproduces the generator rows exactly.

// File: rtl/cc_enc_pkg.sv
package cc_enc_pkg;

    // Code geometry
    localparam int unsigned K_LEN    = 7;              // constraint length
    localparam int unsigned MEM_LEN  = K_LEN - 1;      // history bits
    localparam int unsigned N_OUT    = 2;              // symbols per input bit

    // Generators, first symbol in the upper slice. MSB of each slice taps the current bit.
    localparam logic [N_OUT*K_LEN-1:0] GEN_PACKED = {7'o171, 7'o133};

    typedef logic [MEM_LEN-1:0] hist_t;

    typedef struct packed {
        hist_t hist;
    } enc_reg_t;

endpackage

// File: rtl/cc_parity_tap.sv
module cc_parity_tap #(
    parameter int unsigned WIDTH = 7,
    parameter logic [WIDTH-1:0] TAPS = '1
) (
    input  logic [WIDTH-1:0] word_i,
    output logic             par_o
);

    logic [WIDTH-1:0] masked;

    always_comb begin
        masked = word_i & TAPS;
        par_o  = ^masked;
    end

endmodule

// File: rtl/cc_hist_reg.sv
module cc_hist_reg
    import cc_enc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr_i,
    input  logic  shift_i,
    input  logic  din_i,
    output hist_t hist_o
);

    enc_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d.hist = '0;
        end else if (shift_i) begin
            // newest past bit in the top position, oldest dropped from bit 0
            r_d.hist = {din_i, r_q.hist[MEM_LEN-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hist_o = r_q.hist;

endmodule

// File: rtl/cc_r12_k7_enc.sv
module cc_r12_k7_enc
    import cc_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    input  logic             in_bit_i,
    output logic             out_valid_o,
    output logic [N_OUT-1:0] out_sym_o
);

    hist_t            state_q;
    logic             accept;
    logic [K_LEN-1:0] tap_word;
    logic [N_OUT-1:0] par;

    always_comb begin
        in_ready_o  = ~clr_i;
        accept      = in_valid_i & ~clr_i;
        out_valid_o = accept;
        tap_word    = {in_bit_i, state_q};
        out_sym_o   = par;
    end

    cc_hist_reg u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .shift_i (accept),
        .din_i   (in_bit_i),
        .hist_o  (state_q)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_sym
        localparam logic [K_LEN-1:0] GEN_G = GEN_PACKED[(N_OUT-1-g)*K_LEN +: K_LEN];
        cc_parity_tap #(
            .WIDTH (K_LEN),
            .TAPS  (GEN_G)
        ) u_par (
            .word_i (tap_word),
            .par_o  (par[N_OUT-1-g])
        );
    end

endmodule

// File: rtl/cc_r12_k7_enc_chk.sv
module cc_r12_k7_enc_chk
    import cc_enc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic             in_valid_i,
    input logic             in_ready_o,
    input logic             in_bit_i,
    input logic             out_valid_o,
    input logic [N_OUT-1:0] out_sym_o,
    input hist_t            state_q
);

    logic acc;
    assign acc = in_valid_i & in_ready_o;

    assert_valid_needs_offer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> in_valid_i);

    assert_idle_no_symbol_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |-> !out_valid_o);

    assert_newest_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !clr_i) |=> state_q[MEM_LEN-1] == $past(in_bit_i));

    assert_history_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !clr_i) |=> state_q[MEM_LEN-2:0] == $past(state_q[MEM_LEN-1:1]));

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !clr_i) |=> $stable(state_q));

    assert_clear_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |-> !in_ready_o);

    assert_clear_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> state_q == '0);

    assert_zero_in_zero_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && state_q == '0 && !in_bit_i) |-> out_sym_o == '0);

endmodule

bind cc_r12_k7_enc cc_r12_k7_enc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_bit_i    (in_bit_i),
    .out_valid_o (out_valid_o),
    .out_sym_o   (out_sym_o),
    .state_q     (state_q)
);

// File: tb/cc_r12_k7_enc_tb_top.sv
module cc_r12_k7_enc_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       clr_i;
    logic       in_valid_i;
    logic       in_ready_o;
    logic       in_bit_i;
    logic       out_valid_o;
    logic [1:0] out_sym_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference history: h[1] = most recent past bit ... h[6] = oldest
    bit h [1:6];

    always #(CLK_PERIOD/2) clk = ~clk;

    cc_r12_k7_enc dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .in_valid_i  (in_valid_i),
        .in_ready_o  (in_ready_o),
        .in_bit_i    (in_bit_i),
        .out_valid_o (out_valid_o),
        .out_sym_o   (out_sym_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 1; i <= 6; i++) h[i] = 0;
    endtask

    // one cycle: drive at negedge, compare shortly after, update model at posedge
    task automatic step(input bit v, input bit b, input bit c, input string req);
        bit s1, s2;
        @(negedge clk);
        in_valid_i = v; in_bit_i = b; clr_i = c;
        #1;
        check({req, " ready"}, int'(in_ready_o), int'(!c));
        check({req, " valid"}, int'(out_valid_o), int'(v && !c));
        if (v && !c) begin
            s1 = b ^ h[1] ^ h[2] ^ h[3] ^ h[6];   // 171 octal
            s2 = b ^ h[2] ^ h[3] ^ h[5] ^ h[6];   // 133 octal
            check({req, " sym1"}, int'(out_sym_o[1]), int'(s1));
            check({req, " sym0"}, int'(out_sym_o[0]), int'(s2));
        end
        @(posedge clk);
        if (c) model_clear();
        else if (v) begin
            for (int i = 6; i >= 2; i--) h[i] = h[i-1];
            h[1] = b;
        end
    endtask

    task automatic t_reset();
        rst_n = 0; clr_i = 0; in_valid_i = 0; in_bit_i = 0;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ready in reset", int'(in_ready_o), 1);
        check("R1 valid in reset", int'(out_valid_o), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 valid after reset", int'(out_valid_o), 0);
        // history zero after reset: a zero bit gives 00
        step(1, 0, 0, "R1 zero state");
    endtask

    task automatic t_impulse(input string req);
        // generator rows pair by pair: 11,10,11,11,00,01,11 then 00
        bit [1:0] expv [0:7];
        expv = '{2'b11, 2'b10, 2'b11, 2'b11, 2'b00, 2'b01, 2'b11, 2'b00};
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            in_valid_i = 1; in_bit_i = (k == 0); clr_i = 0;
            #1;
            check({req, " R3 impulse sym1"}, int'(out_sym_o[1]), int'(expv[k][1]));
            check({req, " R4 impulse sym0"}, int'(out_sym_o[0]), int'(expv[k][0]));
            @(posedge clk);
            for (int i = 6; i >= 2; i--) h[i] = h[i-1];
            h[1] = (k == 0);
        end
    endtask

    task automatic t_ones();
        for (int k = 0; k < 10; k++) step(1, 1, 0, "R3 R4 ones");
        @(negedge clk);
        in_valid_i = 1; in_bit_i = 1;
        #1;
        check("R3 ones weight", int'(out_sym_o[1]), 1);
        check("R4 ones weight", int'(out_sym_o[0]), 1);
        in_valid_i = 0;
    endtask

    task automatic t_stream_stall();
        logic [15:0] lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:2] == 2'b00) step(0, ~lfsr[0], 0, "R6 stall");
            else                    step(1, lfsr[0], 0, "R5 stream");
        end
    endtask

    task automatic t_tail();
        for (int k = 0; k < 6; k++) step(1, 0, 0, "R8 tail");
        for (int i = 1; i <= 6; i++) check("R8 model zero", int'(h[i]), 0);
        t_impulse("R8 after tail");
    endtask

    task automatic t_clear();
        for (int k = 0; k < 5; k++) step(1, k[0] | k[1], 0, "R7 pre");
        step(1, 1, 1, "R7 clear");
        t_impulse("R7 after clear");
    endtask

    initial begin
        t_reset();
        t_impulse("R2");
        t_ones();
        t_stream_stall();
        t_tail();
        t_stream_stall();
        t_clear();
        @(negedge clk);
        in_valid_i = 0;
        #1;
        check("R2 idle valid", int'(out_valid_o), 0);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule